// File: doc/BRIEF.md
# Field-Aware Video Blanking and Sync-Flag Generator

This block turns incoming horizontal and vertical sync into per-pixel timing flags for a digitised video stream. A pixel counter restarts on every rising edge of the horizontal sync. A line counter restarts on every rising edge of the vertical sync. From those two counts and a small set of byte-wide configuration registers, the block derives five outputs:

- a data-enable (active video) flag;
- an embedded-sync vertical blanking bit;
- a field bit;
- a one-cycle marker at the pixel where the end-of-active-video code belongs;
- a field identifier that moves only together with the vertical sync output.

Each field has its own vertical blanking window, given as a start offset and a length in lines after the vertical sync edge. The field bit has a signed start offset. None of these settings moves the vertical sync output. The active-video stop pixel is 13 bits wide and is written as two bytes. The low byte waits in a shadow register. The whole value takes effect only when the high byte is written, so the stop point never holds a half-updated value. All flag outputs are registered and appear one clock after the pixel they describe.

Top module: `vid_flag_gen`

## Requirements
- R1: After reset all outputs are 0. The configuration resets to: active start 0x0104, active stop 0x062C, blanking start 5 and blanking length 30 for both fields, field-bit start 0, progressive mode.
- R2: Register map (address: content). 0: stop low byte, which is shadowed only. 1: stop bits 12:8 in wdata[4:0]; writing it loads the whole stop value {wdata[4:0], shadow}. 2: start low byte. 3: start bits 12:8 in wdata[4:0]. 4 and 5: blanking start for field 0 and field 1. 6 and 7: blanking length for field 0 and field 1. 8: signed field-bit start. 9: bit 0 is 1 for interlaced. A write to address 0 alone leaves the stop position in use unchanged.
- R3: Let the span be stop minus start. When stop > start, the effective stop is stop minus (span mod 2). de_out is high for pixels P with start <= P < effective stop, except on blanking lines.
- R4: eav_out pulses for exactly one pixel, at P equal to the effective stop, and only when stop > start. It is never high together with de_out.
- R5: The clock cycle in which hsync_in is first seen high is pixel 0. Every flag output reflects its pixel one clock later.
- R6: The clock cycle in which vsync_in is first seen high is line 0. Each later hsync rising edge adds one line. vbit_out is high on lines L with S <= L < S+N, where S and N are the blanking start and blanking length of the current field.
- R7: de_out is low on every line where vbit_out is high.
- R8: vsync_out equals vsync_in delayed by one clock, whatever the blanking and field settings are.
- R9: In interlaced mode the field toggles at each vsync rising edge. In progressive mode the field is 0. fid_out shows the field and changes only in the cycle where vsync_out rises.
- R10: fbit_out is 1 only in interlaced mode, in field 1, on lines L where L >= the signed field-bit start. Otherwise it is 0.
- R11: wdata[7:5] of a stop or start high-byte write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| de_out | output | 1 | Active-video / data enable |
| vbit_out | output | 1 | Embedded-sync vertical blanking bit |
| fbit_out | output | 1 | Embedded-sync field bit |
| eav_out | output | 1 | End-of-active-video code position marker |
| fid_out | output | 1 | Field identifier, aligned to vsync_out |
| vsync_out | output | 1 | Vertical sync delayed by one clock |

## Verification
The hardest situation to reach is the pair of fields in interlaced mode. There the blanking windows of the two fields differ and the signed field-bit start cuts into field 1 only. Seeing this needs several whole frames run back to back, with the field parity carried from one frame to the next. The stimulus runs short, 40-pixel lines in 12-line frames. It first uses a positive field-bit offset and then a negative one. Every pixel of every line is compared against an arithmetic model of the requirements that keeps its own field parity. The shadowed stop write is checked by running a full frame between the low-byte write and the high-byte write.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
    localparam int PIX_W = 13;

    localparam logic [3:0] A_STOP_LO  = 4'd0;
    localparam logic [3:0] A_STOP_HI  = 4'd1;
    localparam logic [3:0] A_START_LO = 4'd2;
    localparam logic [3:0] A_START_HI = 4'd3;
    localparam logic [3:0] A_VBS0     = 4'd4;
    localparam logic [3:0] A_VBS1     = 4'd5;
    localparam logic [3:0] A_VBL0     = 4'd6;
    localparam logic [3:0] A_VBL1     = 4'd7;
    localparam logic [3:0] A_FSTART   = 4'd8;
    localparam logic [3:0] A_MODE     = 4'd9;

    typedef struct packed {
        logic [PIX_W-1:0] act_start;
        logic [PIX_W-1:0] act_stop;
        logic [7:0]       stop_lo_sh;
        logic [7:0]       vb_start0;
        logic [7:0]       vb_start1;
        logic [7:0]       vb_len0;
        logic [7:0]       vb_len1;
        logic [7:0]       f_start;
        logic             interlace;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        act_start:  13'h0104,
        act_stop:   13'h062C,
        stop_lo_sh: 8'h2C,
        vb_start0:  8'd5,
        vb_start1:  8'd5,
        vb_len0:    8'd30,
        vb_len1:    8'd30,
        f_start:    8'd0,
        interlace:  1'b0
    };
endpackage

// File: rtl/vfg_regs.sv
module vfg_regs
    import vfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output cfg_t       cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                A_STOP_LO:  cfg_d.stop_lo_sh = wdata;
                A_STOP_HI:  cfg_d.act_stop   = {wdata[4:0], cfg_q.stop_lo_sh};
                A_START_LO: cfg_d.act_start[7:0] = wdata;
                A_START_HI: cfg_d.act_start[PIX_W-1:8] = wdata[4:0];
                A_VBS0:     cfg_d.vb_start0 = wdata;
                A_VBS1:     cfg_d.vb_start1 = wdata;
                A_VBL0:     cfg_d.vb_len0   = wdata;
                A_VBL1:     cfg_d.vb_len1   = wdata;
                A_FSTART:   cfg_d.f_start   = wdata;
                A_MODE:     cfg_d.interlace = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/vfg_count.sv
module vfg_count
    import vfg_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              interlace,
    output logic [PIX_W-1:0]  cur_pix,
    output logic [LINE_W-1:0] cur_line,
    output logic              cur_field
);
    localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    typedef struct packed {
        logic              hs;
        logic              vs;
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
        logic              field;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic hs_edge, vs_edge;

    always_comb begin
        hs_edge = hsync && !cnt_q.hs;
        vs_edge = vsync && !cnt_q.vs;
        cnt_d    = cnt_q;
        cnt_d.hs = hsync;
        cnt_d.vs = vsync;
        if (hs_edge)                cnt_d.pix = '0;
        else if (cnt_q.pix != PIX_MAX) cnt_d.pix = cnt_q.pix + 1'b1;
        if (vs_edge)                cnt_d.line = '0;
        else if (hs_edge && cnt_q.line != LINE_MAX) cnt_d.line = cnt_q.line + 1'b1;
        if (!interlace)             cnt_d.field = 1'b0;
        else if (vs_edge)           cnt_d.field = !cnt_q.field;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            cnt_q.pix   <= PIX_MAX;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cur_pix   = cnt_d.pix;
    assign cur_line  = cnt_d.line;
    assign cur_field = cnt_d.field;
endmodule

// File: rtl/vfg_flags.sv
module vfg_flags
    import vfg_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic [PIX_W-1:0]  cur_pix,
    input  logic [LINE_W-1:0] cur_line,
    input  logic              cur_field,
    input  logic              vsync,
    output logic              de,
    output logic              vbit,
    output logic              fbit,
    output logic              eav,
    output logic              fid,
    output logic              vso
);
    localparam int CW = ((LINE_W > 9) ? LINE_W : 9) + 1;

    typedef struct packed {
        logic de;
        logic vbit;
        logic fbit;
        logic eav;
        logic fid;
        logic vso;
    } flg_t;

    flg_t flg_d, flg_q;
    logic [PIX_W-1:0] span, stop_eff;
    logic             has_span;
    logic [CW-1:0]    line_x, vb_lo, vb_hi;
    logic             in_vb;

    always_comb begin
        has_span = cfg.act_stop > cfg.act_start;
        span     = cfg.act_stop - cfg.act_start;
        stop_eff = cfg.act_stop - {{(PIX_W-1){1'b0}}, span[0]};
        line_x   = CW'(cur_line);
        vb_lo    = cur_field ? CW'(cfg.vb_start1) : CW'(cfg.vb_start0);
        vb_hi    = vb_lo + (cur_field ? CW'(cfg.vb_len1) : CW'(cfg.vb_len0));
        in_vb    = (line_x >= vb_lo) && (line_x < vb_hi);

        flg_d.vbit = in_vb;
        flg_d.de   = has_span && !in_vb && (cur_pix >= cfg.act_start) && (cur_pix < stop_eff);
        flg_d.eav  = has_span && (cur_pix == stop_eff);
        flg_d.fbit = cfg.interlace && cur_field &&
                     ($signed({1'b0, line_x}) >= $signed(cfg.f_start));
        flg_d.fid  = cur_field;
        flg_d.vso  = vsync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign de   = flg_q.de;
    assign vbit = flg_q.vbit;
    assign fbit = flg_q.fbit;
    assign eav  = flg_q.eav;
    assign fid  = flg_q.fid;
    assign vso  = flg_q.vso;
endmodule

// File: rtl/vid_flag_gen.sv
module vid_flag_gen
    import vfg_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_in,
    input  logic       vsync_in,
    input  logic       reg_wr_en,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic       de_out,
    output logic       vbit_out,
    output logic       fbit_out,
    output logic       eav_out,
    output logic       fid_out,
    output logic       vsync_out
);
    cfg_t              cfg_w;
    logic [PIX_W-1:0]  pix_w;
    logic [LINE_W-1:0] line_w;
    logic              field_w;

    vfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg_w)
    );

    vfg_count #(.LINE_W(LINE_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync_in),
        .vsync     (vsync_in),
        .interlace (cfg_w.interlace),
        .cur_pix   (pix_w),
        .cur_line  (line_w),
        .cur_field (field_w)
    );

    vfg_flags #(.LINE_W(LINE_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_w),
        .cur_pix   (pix_w),
        .cur_line  (line_w),
        .cur_field (field_w),
        .vsync     (vsync_in),
        .de        (de_out),
        .vbit      (vbit_out),
        .fbit      (fbit_out),
        .eav       (eav_out),
        .fid       (fid_out),
        .vso       (vsync_out)
    );
endmodule

// File: rtl/vid_flag_gen_chk.sv
module vid_flag_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [3:0]  reg_addr,
    input logic [12:0] stop_val,
    input logic        de_out,
    input logic        vbit_out,
    input logic        fbit_out,
    input logic        eav_out,
    input logic        fid_out,
    input logic        vsync_out
);
    // R2
    stop_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == 4'd1) |=> $stable(stop_val));

    // R4
    eav_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eav_out |=> !eav_out);

    // R4
    eav_not_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eav_out |-> !de_out);

    // R7
    de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbit_out |-> !de_out);

    // R9
    fid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fid_out != $past(fid_out)) |-> $rose(vsync_out));

    // R10
    fbit_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_out |-> fid_out);
endmodule

bind vid_flag_gen vid_flag_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .stop_val  (cfg_w.act_stop),
    .de_out    (de_out),
    .vbit_out  (vbit_out),
    .fbit_out  (fbit_out),
    .eav_out   (eav_out),
    .fid_out   (fid_out),
    .vsync_out (vsync_out)
);

// File: tb/vid_flag_gen_tb.sv
module vid_flag_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0, vs = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       de, vb, fb, ev, fid, vso;

    int checks = 0;
    int fails  = 0;

    // bench-side model of the configuration
    int m_start = 'h104, m_stop = 'h62C, m_sh = 'h2C;
    int m_vbs[2] = '{5, 5};
    int m_vbl[2] = '{30, 30};
    int m_fs = 0;
    bit m_il = 1'b0;
    bit m_field = 1'b0;

    bit   exp_valid = 1'b0;
    logic e_de, e_vb, e_fb, e_ev, e_fid, e_vso;
    string phase = "R1";

    always #2 clk = ~clk;

    vid_flag_gen dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
        .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata),
        .de_out(de), .vbit_out(vb), .fbit_out(fb), .eav_out(ev),
        .fid_out(fid), .vsync_out(vso)
    );

    task automatic cmp(string req, logic act, logic exp, string nm);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (%s): actual=%b expected=%b", req, nm, phase, act, exp);
        end
    endtask

    task automatic check_outputs();
        if (exp_valid) begin
            cmp("R3", de,  e_de,  "de_out");
            cmp("R6", vb,  e_vb,  "vbit_out");
            cmp("R10", fb, e_fb,  "fbit_out");
            cmp("R4", ev,  e_ev,  "eav_out");
            cmp("R9", fid, e_fid, "fid_out");
            cmp("R8", vso, e_vso, "vsync_out");
        end
    endtask

    task automatic write_reg(int a, int d);
        @(negedge clk);
        check_outputs();
        exp_valid = 1'b0;
        wr = 1'b1; addr = 4'(a); wdata = 8'(d);
        case (a)
            0: m_sh = d;
            1: m_stop = ((d & 'h1F) << 8) | m_sh;
            2: m_start = (m_start & 'h1F00) | d;
            3: m_start = (m_start & 'hFF) | ((d & 'h1F) << 8);
            4: m_vbs[0] = d;
            5: m_vbs[1] = d;
            6: m_vbl[0] = d;
            7: m_vbl[1] = d;
            8: m_fs = (d > 127) ? d - 256 : d;
            9: m_il = d[0];
            default: ;
        endcase
        @(negedge clk);
        wr = 1'b0;
    endtask

    // drives one frame; pixel 0 of line 0 carries both sync edges
    task automatic run_frame(int nlines, int llen, int hsw, int vsl);
        int span, eff;
        bit has, inb;
        for (int l = 0; l < nlines; l++) begin
            for (int p = 0; p < llen; p++) begin
                @(negedge clk);
                check_outputs();
                hs = (p < hsw);
                vs = (l < vsl);
                if (l == 0 && p == 0) m_field = m_il ? !m_field : 1'b0;
                has  = m_stop > m_start;
                span = m_stop - m_start;
                eff  = m_stop - (span % 2);
                inb  = (l >= m_vbs[m_field]) && (l < m_vbs[m_field] + m_vbl[m_field]);
                e_vb  = inb;
                e_de  = has && !inb && p >= m_start && p < eff;
                e_ev  = has && p == eff;
                e_fb  = m_il && m_field && (l >= m_fs);
                e_fid = m_field;
                e_vso = vs;
                exp_valid = 1'b1;
            end
        end
        @(negedge clk);
        check_outputs();
        hs = 1'b0; vs = 1'b0;
        exp_valid = 1'b0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        // R1: outputs zero straight after reset
        cmp("R1", de, 1'b0, "de_out");
        cmp("R1", vb, 1'b0, "vbit_out");
        cmp("R1", fb, 1'b0, "fbit_out");
        cmp("R1", ev, 1'b0, "eav_out");
        cmp("R1", fid, 1'b0, "fid_out");
        cmp("R1", vso, 1'b0, "vsync_out");

        // R1 R5: default configuration over one long line
        run_frame(1, 1600, 4, 1);

        // small configuration, odd span 15 rounds to 14 (R3)
        phase = "R3_R6_R7";
        write_reg(2, 6);   write_reg(3, 0);
        write_reg(0, 21);  write_reg(1, 0);
        write_reg(4, 2);   write_reg(6, 3);
        write_reg(5, 3);   write_reg(7, 2);
        write_reg(8, 4);
        run_frame(12, 40, 4, 2);

        // R2: low byte alone must not move the stop
        phase = "R2_shadow";
        write_reg(0, 30);
        run_frame(12, 40, 4, 2);
        write_reg(1, 0);
        phase = "R2_commit";
        run_frame(12, 40, 4, 2);

        // R11: reserved high bits ignored
        phase = "R11";
        write_reg(0, 24);
        write_reg(1, 'hE0);
        run_frame(12, 40, 4, 2);

        // R9 R10: interlaced fields, positive then negative F start
        phase = "R9_R10_pos";
        write_reg(9, 1);
        for (int f = 0; f < 4; f++) run_frame(12, 40, 4, 2);
        phase = "R9_R10_neg";
        write_reg(8, 'hFF);
        for (int f = 0; f < 2; f++) run_frame(12, 40, 4, 2);

        // R9 R10: back to progressive, field forced to 0
        phase = "R9_prog";
        write_reg(9, 0);
        run_frame(12, 40, 4, 2);

        // R4: stop equal to start gives no active video and no marker
        phase = "R4_empty";
        write_reg(0, 6); write_reg(1, 0);
        run_frame(6, 40, 4, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule